// File: doc/BRIEF.md
# Serial Presence-Detect Configuration EEPROM Slave

This block is a two-wire (I2C) slave that stands in for the small configuration memory found on a memory module. A host reads module identification and timing bytes from it, and it may also store its own bytes there. The storage is 256 bytes held in a register array. At power-up the array is filled with a computed preload. The lower half holds factory data and the upper half is free for the user.

The 7-bit slave address has a fixed device-type prefix and three low bits taken from strap pins, so up to eight such slaves can share one bus. A write transfer carries a word address that sets an internal pointer, and it may carry data bytes. A read continues from that pointer. The pointer advances after every byte and wraps from 255 to 0.

When a stop ends a transfer that carried write data, the block enters a programming interval of `PROG_CYC` clocks. During that interval it ignores its address and leaves SDA released. SCL and SDA pass through digital glitch filters before any bus logic sees them. SDA is driven only low, through an enable output.

Top module: `spd_eeprom_slave`

## Requirements
- R1: After reset, and while no transfer addresses the block, `sda_oe_o` is 0 (SDA released).
- R2: A device byte whose upper seven bits equal {4'b1010, `strap_i`} is acknowledged: SDA is pulled low during the ninth clock. A device byte with any other value in those seven bits gets no acknowledge. Bit 0 of the device byte is 0 for a write and 1 for a read.
- R3: After reset, byte i of the store reads back as (i XOR 8'h5A).
- R4: In a write transfer, the byte after the device byte is the word address. Each later data byte is acknowledged and is stored at the pointer, provided the pointer is 128 or above (the user half).
- R5: A data byte written while the pointer is below 128 (the factory half) is acknowledged but leaves the stored value unchanged.
- R6: The pointer increments after every data byte written or read, and wraps from 255 to 0. A read acknowledged by the master returns consecutive bytes.
- R7: A repeated start is accepted. A read with no word address in front of it continues at the byte after the last one transferred.
- R8: When the master does not acknowledge a read byte, the block drives nothing more until the next start.
- R9: After a stop that ends a transfer with at least one data byte, no device byte is acknowledged for `PROG_CYC` clocks. After that interval, the block answers again.
- R10: A pulse of `FILT_CYC`-1 clocks or shorter on SCL or SDA has no effect on the transfer. With the defaults, a pulse of 40 ns or less at 50 MHz is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad |
| strap_i | input | 3 | Strap bits forming the low slave address bits |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The main function is tried with several patterns:
- random reads at set word addresses, which separate the word-address path from the pointer;
- reads that carry on across 255, which expose wrap errors;
- a current-address read after a repeated start, which shows the pointer kept its value between transfers;
- writes to each half of the array, which tell a stored byte from an acknowledged but discarded one.

Device bytes with a wrong strap value and a wrong type prefix must be refused. An address sent during the programming interval must be refused, while the same address sent after the interval must be accepted. Short pulses are injected on SCL inside an address byte and on SDA inside a data byte; an unfiltered path would misalign the bits or abort the write.

// File: rtl/spd_pkg.sv
package spd_pkg;

  localparam int unsigned SPD_STRAP_W = 3;
  localparam int unsigned SPD_BYTE_W  = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WORD,
    ST_WORD_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } spd_state_e;

  // Power-up content of byte idx
  function automatic logic [SPD_BYTE_W-1:0] spd_preload(input int unsigned idx);
    logic [SPD_BYTE_W-1:0] b;
    b = idx[SPD_BYTE_W-1:0];
    return b ^ 8'h5A;
  endfunction

endpackage

// File: rtl/spd_glitch_filter.sv
module spd_glitch_filter #(
  parameter int unsigned FILT_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic filt_o
);
  localparam int unsigned CW = (FILT_CYC > 2) ? $clog2(FILT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1     <= 1'b1;
      s2     <= 1'b1;
      filt_o <= 1'b1;
      cnt    <= '0;
    end else begin
      s1 <= pin_i;
      s2 <= s1;
      if (s2 != filt_o) begin
        if (cnt == LAST) begin
          filt_o <= s2;
          cnt    <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end

  // output moves only after the synchronized level has held
  AST_FILT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$stable(filt_o) |-> ($past(s2) == filt_o) && ($past(s2, 2) == filt_o)); // R10

endmodule

// File: rtl/spd_bus_events.sv
module spd_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      scl_rise <= 1'b0;
      scl_fall <= 1'b0;
      start_ev <= 1'b0;
      stop_ev  <= 1'b0;
    end else begin
      scl_q    <= scl_f;
      sda_q    <= sda_f;
      scl_rise <= scl_f & ~scl_q;
      scl_fall <= ~scl_f & scl_q;
      start_ev <= scl_f & scl_q & sda_q & ~sda_f;
      stop_ev  <= scl_f & scl_q & ~sda_q & sda_f;
    end
  end

endmodule

// File: rtl/spd_byte_store.sv
module spd_byte_store #(
  parameter int unsigned DEPTH        = 256,
  parameter bit          LOCK_FACTORY = 1'b1,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            we_i,
  input  logic [AW-1:0]                   waddr_i,
  input  logic [spd_pkg::SPD_BYTE_W-1:0]  wdata_i,
  input  logic [AW-1:0]                   raddr_i,
  output logic [spd_pkg::SPD_BYTE_W-1:0]  rdata_o
);
  logic [spd_pkg::SPD_BYTE_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = spd_pkg::spd_preload(i);
  end

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end

  // no write request may target the locked lower half
  AST_FACTORY_LOCKED: assert property (@(posedge clk) disable iff (rst)
    we_i |-> (!LOCK_FACTORY || waddr_i[AW-1])); // R5

endmodule

// File: rtl/spd_prog_timer.sv
module spd_prog_timer #(
  parameter int unsigned PROG_CYC = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic kick_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(PROG_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(PROG_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (kick_i)      cnt <= LOAD;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy_o = (cnt != '0);

  AST_PROG_START: assert property (@(posedge clk) disable iff (rst)
    $past(kick_i) |-> busy_o); // R9

endmodule

// File: rtl/spd_eeprom_slave.sv
module spd_eeprom_slave #(
  parameter int unsigned MEM_DEPTH    = 256,
  parameter int unsigned FILT_CYC     = 3,
  parameter int unsigned PROG_CYC     = 500000,
  parameter bit          LOCK_FACTORY = 1'b1,
  parameter logic [3:0]  DEV_TYPE     = 4'b1010
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          scl_i,
  input  logic                          sda_i,
  input  logic [spd_pkg::SPD_STRAP_W-1:0] strap_i,
  output logic                          sda_oe_o
);
  import spd_pkg::*;

  localparam int unsigned AW = $clog2(MEM_DEPTH);
  localparam int unsigned BW = SPD_BYTE_W;

  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_ev, stop_ev;
  logic busy, prog_kick;

  spd_glitch_filter #(.FILT_CYC(FILT_CYC)) u_filt_scl (
    .clk(clk), .rst(rst), .pin_i(scl_i), .filt_o(scl_f));
  spd_glitch_filter #(.FILT_CYC(FILT_CYC)) u_filt_sda (
    .clk(clk), .rst(rst), .pin_i(sda_i), .filt_o(sda_f));

  spd_bus_events u_events (
    .clk(clk), .rst(rst), .scl_f(scl_f), .sda_f(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev));

  spd_prog_timer #(.PROG_CYC(PROG_CYC)) u_timer (
    .clk(clk), .rst(rst), .kick_i(prog_kick), .busy_o(busy));

  spd_state_e    state;
  logic [3:0]    bitcnt;
  logic [BW-1:0] shreg, txreg;
  logic [AW-1:0] ptr;
  logic          rw_q, wr_seen, mst_ack;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [BW-1:0] mem_wdata, rd_q;
  logic          in_factory;

  spd_byte_store #(.DEPTH(MEM_DEPTH), .LOCK_FACTORY(LOCK_FACTORY)) u_store (
    .clk(clk), .rst(rst), .we_i(mem_we), .waddr_i(mem_waddr),
    .wdata_i(mem_wdata), .raddr_i(ptr), .rdata_o(rd_q));

  assign in_factory = LOCK_FACTORY && !ptr[AW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      txreg     <= '0;
      ptr       <= '0;
      rw_q      <= 1'b0;
      wr_seen   <= 1'b0;
      mst_ack   <= 1'b0;
      sda_oe_o  <= 1'b0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
      prog_kick <= 1'b0;
    end else begin
      mem_we    <= 1'b0;
      prog_kick <= 1'b0;
      if (start_ev) begin
        sda_oe_o <= 1'b0;
        bitcnt   <= '0;
        state    <= busy ? ST_IDLE : ST_DEV;
      end else if (stop_ev) begin
        sda_oe_o <= 1'b0;
        state    <= ST_IDLE;
        if (wr_seen) prog_kick <= 1'b1;
        wr_seen  <= 1'b0;
      end else begin
        case (state)
          ST_DEV, ST_WORD, ST_WDATA: begin
            if (scl_rise) begin
              shreg  <= {shreg[BW-2:0], sda_f};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              sda_oe_o <= 1'b1;
              if (state == ST_DEV) begin
                if (shreg[BW-1:1] == {DEV_TYPE, strap_i}) begin
                  rw_q  <= shreg[0];
                  state <= ST_DEV_ACK;
                end else begin
                  sda_oe_o <= 1'b0;
                  state    <= ST_IDLE;
                end
              end else if (state == ST_WORD) begin
                ptr   <= shreg[AW-1:0];
                state <= ST_WORD_ACK;
              end else begin
                mem_we    <= !in_factory;
                mem_waddr <= ptr;
                mem_wdata <= shreg;
                ptr       <= ptr + 1'b1;
                wr_seen   <= 1'b1;
                state     <= ST_WDATA_ACK;
              end
            end
          end
          ST_DEV_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rw_q) begin
                txreg    <= rd_q;
                sda_oe_o <= ~rd_q[BW-1];
                ptr      <= ptr + 1'b1;
                state    <= ST_RDATA;
              end else begin
                sda_oe_o <= 1'b0;
                state    <= ST_WORD;
              end
            end
          end
          ST_WORD_ACK, ST_WDATA_ACK: begin
            if (scl_fall) begin
              sda_oe_o <= 1'b0;
              bitcnt   <= '0;
              state    <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_oe_o <= 1'b0;
                state    <= ST_RACK;
              end else begin
                txreg    <= {txreg[BW-2:0], 1'b0};
                sda_oe_o <= ~txreg[BW-2];
                bitcnt   <= bitcnt + 1'b1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mst_ack <= ~sda_f;
            end else if (scl_fall) begin
              bitcnt <= '0;
              if (mst_ack) begin
                txreg    <= rd_q;
                sda_oe_o <= ~rd_q[BW-1];
                ptr      <= ptr + 1'b1;
                state    <= ST_RDATA;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // nothing is driven during the programming interval
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_oe_o); // R9

  // the drive enable only moves while the filtered clock is low
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe_o) |-> !scl_f); // R8

endmodule

// File: tb/spd_eeprom_slave_tb.sv
module spd_eeprom_slave_tb;

  localparam int Q      = 12;
  localparam int PROG   = 400;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sdal_m = 1'b0;
  logic dut_oe;
  logic sda_bus;

  always #10 clk = ~clk;

  assign sda_bus = !(sdal_m || dut_oe);

  spd_eeprom_slave #(.PROG_CYC(PROG)) u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
    .strap_i(STRAP), .sda_oe_o(dut_oe));

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  string exp_tag[$];
  int    exp_val[$];
  int    obs_val[$];
  logic [7:0] shadow [256];

  task automatic tk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_item(input string tag, input int v);
    exp_tag.push_back(tag);
    exp_val.push_back(v);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (obs_val.size() > 0 && exp_val.size() > 0) begin
        automatic int    o = obs_val.pop_front();
        automatic int    e = exp_val.pop_front();
        automatic string t = exp_tag.pop_front();
        total++;
        if (o != e) begin
          bad++;
          $display("FAIL %s: actual=%0h expected=%0h", t, o, e);
        end
      end
    end
  end

  task automatic bus_start;
    sdal_m = 1'b0; tk(Q); scl_m = 1'b1; tk(Q);
    sdal_m = 1'b1; tk(Q); scl_m = 1'b0; tk(Q);
  endtask

  task automatic bus_stop;
    sdal_m = 1'b1; tk(Q); scl_m = 1'b1; tk(Q); sdal_m = 1'b0; tk(Q);
  endtask

  // glitch: 0 none, 1 short low pulse on SCL each bit, 2 short low pulse on SDA for 1-bits
  task automatic put_byte(input logic [7:0] b, input int glitch, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdal_m = !b[i]; tk(Q); scl_m = 1'b1; tk(Q);
      if (glitch == 1) begin scl_m = 1'b0; tk(2); scl_m = 1'b1; end
      if (glitch == 2 && b[i]) begin sdal_m = 1'b1; tk(2); sdal_m = 1'b0; end
      tk(Q); scl_m = 1'b0; tk(Q);
    end
    sdal_m = 1'b0; tk(Q); scl_m = 1'b1; tk(Q);
    ack = !sda_bus;
    tk(Q); scl_m = 1'b0; tk(Q);
  endtask

  task automatic get_byte(input logic mack, output logic [7:0] b);
    sdal_m = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tk(Q); scl_m = 1'b1; tk(Q); b[i] = sda_bus; tk(Q); scl_m = 1'b0;
    end
    tk(Q - 2);
    sdal_m = mack; tk(2); scl_m = 1'b1; tk(2 * Q); scl_m = 1'b0; tk(Q);
    sdal_m = 1'b0;
  endtask

  task automatic send_checked(input logic [7:0] b, input int glitch, input string tag, input int want);
    logic a;
    expect_item(tag, want);
    put_byte(b, glitch, a);
    obs_val.push_back(int'(a));
  endtask

  task automatic read_run(input int n, input logic [7:0] first, input string tag, input bit nack_chk);
    logic [7:0] d;
    for (int k = 0; k < n; k++) begin
      expect_item(tag, int'(shadow[8'(first + k)]));
      get_byte(k < n - 1, d);
      obs_val.push_back(int'(d));
    end
    if (nack_chk) begin
      // R8: after the master's NACK nothing is driven before the stop
      tk(Q);
      expect_item("R8", 0);
      obs_val.push_back(int'(dut_oe));
    end
  endtask

  task automatic random_read(input logic [7:0] a, input int n, input string tag);
    bus_start;
    send_checked(DEV_W, 0, "R2", 1);
    send_checked(a, 0, "R2", 1);
    bus_start;                              // repeated start, R7
    send_checked(DEV_R, 0, "R7", 1);
    read_run(n, a, tag, 1'b0);
    bus_stop;
  endtask

  task automatic write_run(input logic [7:0] a, input int n, input logic [7:0] d0,
                           input logic [7:0] d1, input logic [7:0] d2, input int glitch,
                           input string tag);
    logic [7:0] dv [3];
    dv[0] = d0; dv[1] = d1; dv[2] = d2;
    bus_start;
    send_checked(DEV_W, 0, "R2", 1);
    send_checked(a, 0, "R4", 1);
    for (int k = 0; k < n; k++) begin
      automatic logic [7:0] p = 8'(a + k);
      send_checked(dv[k], glitch, tag, 1);
      if (p[7]) shadow[p] = dv[k];
    end
    bus_stop;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) shadow[i] = 8'(i) ^ 8'h5A;
    tk(5);
    rst = 1'b0;
    tk(5);
    // R1 reset state
    expect_item("R1", 0);
    obs_val.push_back(int'(dut_oe));

    // R3 preload
    random_read(8'h10, 1, "R3");
    random_read(8'hC7, 2, "R3");

    // R2 address mismatches
    bus_start;
    send_checked({4'b1010, 3'b100, 1'b0}, 0, "R2", 0);
    bus_stop;
    bus_start;
    send_checked({4'b0100, STRAP, 1'b0}, 0, "R2", 0);
    bus_stop;
    tk(4);
    expect_item("R1", 0);
    obs_val.push_back(int'(dut_oe));

    // R4 user write, R9 busy window
    write_run(8'h90, 1, 8'hC3, 8'h00, 8'h00, 0, "R4");
    bus_start;
    send_checked(DEV_R, 0, "R9", 0);
    bus_stop;
    tk(PROG + 50);
    bus_start;
    send_checked(DEV_W, 0, "R9", 1);
    send_checked(8'h90, 0, "R9", 1);
    bus_start;
    send_checked(DEV_R, 0, "R9", 1);
    read_run(1, 8'h90, "R4", 1'b0);
    bus_stop;

    // R5 factory write discarded
    write_run(8'h10, 1, 8'h00, 8'h00, 8'h00, 0, "R5");
    tk(PROG + 50);
    random_read(8'h10, 1, "R5");

    // R6 sequential write across wrap, then sequential read across wrap
    write_run(8'hFE, 3, 8'h11, 8'h22, 8'h33, 0, "R6");
    tk(PROG + 50);
    random_read(8'hFD, 4, "R6");

    // R7/R8: NACK ends read; current-address read continues
    bus_start;
    send_checked(DEV_W, 0, "R2", 1);
    send_checked(8'h20, 0, "R2", 1);
    bus_start;
    send_checked(DEV_R, 0, "R7", 1);
    read_run(1, 8'h20, "R7", 1'b1);
    bus_stop;
    bus_start;
    send_checked(DEV_R, 0, "R7", 1);
    read_run(2, 8'h21, "R7", 1'b0);
    bus_stop;

    // R10 short pulses on SCL in the device byte and on SDA in the data byte
    bus_start;
    send_checked(DEV_W, 1, "R10", 1);
    send_checked(8'h95, 0, "R10", 1);
    send_checked(8'hF0, 2, "R10", 1);
    shadow[8'h95] = 8'hF0;
    bus_stop;
    tk(PROG + 50);
    random_read(8'h95, 1, "R10");

    tk(10);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule